// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Flags

This block sits between a register/DMA side and a serial audio transceiver. It holds two independent first-in first-out buffers of 32-bit sample words, eight entries deep: one carries words from the bus towards the transmitter, the other carries words captured by the receiver back towards the bus. Each buffer has its own push and pop handshake, reports how many words it holds, and raises a programmable threshold flag. Software or a DMA engine uses this flag to decide when to refill the transmit side or drain the receive side.

The two threshold flags use opposite comparison senses. The transmit flag says "running low". The receive flag says "enough words have arrived". The receive field is encoded with an offset of one, so its three bits can express a threshold of eight words. A flush command on each side returns the pointers and the level to zero in one cycle without erasing the storage. An enable input on each side turns the fill state into a DMA request: transmit requests while not full, receive requests while not empty.

Top module: `audio_fifo_pair`

## Requirements
- R1: After `rst_ni` is released, both levels are 0 and all four sticky flags are 0. `tx_thresh_o` is 1. `rx_thresh_o` is 0. `rx_dreq_o` is 0. `tx_dreq_o` equals `tx_dma_en_i`.
- R2: Each buffer returns words in the order they were pushed. The head word is shown on `*_data_o` while the level is non-zero. The level is 4 bits wide, ranges over 0..8, and changes on the clock edge after an accepted push or pop.
- R3: `tx_thresh_o` is 1 exactly when `tx_level_o` <= `tx_thresh_i`. Field value N (0..7) means N words.
- R4: `rx_thresh_o` is 1 exactly when `rx_level_o` >= `rx_thresh_i` + 1. Field value N (0..7) means N+1 words, so the range is 1..8.
- R5: A flush pulse on `*_flush_i` sets the level to 0 and both pointers to slot 0 at the next edge. It also clears that side's sticky flags. A flush wins over a push or pop in the same cycle. The flush is a command, not a stored bit: it has effect only in the cycles it is high.
- R6: A flush does not erase storage. While a buffer is empty, `*_data_o` shows the slot under the read pointer. Right after a flush this is the word last written into slot 0.
- R7: `tx_dreq_o` is 1 exactly when `tx_dma_en_i` is 1 and the transmit level is below 8.
- R8: `rx_dreq_o` is 1 exactly when `rx_dma_en_i` is 1 and the receive level is above 0.
- R9: A push while the level is 8 is dropped, even if a pop happens in the same cycle. The drop sets `*_ovf_o`, which stays set until reset or flush.
- R10: A pop while the level is 0 is dropped, even if a push happens in the same cycle. The drop sets `*_unf_o`, which stays set until reset or flush.
- R11: A push and a pop accepted in the same cycle leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_push_i | input | 1 | Write one word into the transmit buffer |
| tx_wdata_i | input | DATA_W | Word written on a transmit push |
| tx_pop_i | input | 1 | Transmitter consumes the head word |
| tx_data_o | output | DATA_W | Transmit head word |
| tx_flush_i | input | 1 | Flush command for the transmit buffer |
| tx_thresh_i | input | TH_W | Transmit low-water field (N words) |
| tx_dma_en_i | input | 1 | Transmit DMA request enable |
| tx_level_o | output | LVL_W | Transmit occupancy |
| tx_thresh_o | output | 1 | Transmit level at or below the field |
| tx_dreq_o | output | 1 | Transmit DMA request |
| tx_ovf_o | output | 1 | Sticky transmit overflow |
| tx_unf_o | output | 1 | Sticky transmit underflow |
| rx_push_i | input | 1 | Receiver delivers one word |
| rx_wdata_i | input | DATA_W | Word delivered by the receiver |
| rx_pop_i | input | 1 | Bus side reads the head word |
| rx_data_o | output | DATA_W | Receive head word |
| rx_flush_i | input | 1 | Flush command for the receive buffer |
| rx_thresh_i | input | TH_W | Receive high-water field (N+1 words) |
| rx_dma_en_i | input | 1 | Receive DMA request enable |
| rx_level_o | output | LVL_W | Receive occupancy |
| rx_thresh_o | output | 1 | Receive level at or above the field plus one |
| rx_dreq_o | output | 1 | Receive DMA request |
| rx_ovf_o | output | 1 | Sticky receive overflow |
| rx_unf_o | output | 1 | Sticky receive underflow |

## Verification
The assertions assume the handshake inputs are known, 0 or 1, at every clock edge after reset. They make no assumption about order: a push into a full buffer or a pop from an empty one is legal stimulus, and the properties describe what it does. The bench drives every input just after the falling edge and holds it through the next rising edge. It deliberately hits the full, empty and same-cycle flush cases, so that the conditional properties are triggered and not only left idle.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  parameter int DATA_W = 32;
  parameter int DEPTH  = 8;
  parameter int TH_W   = 3;
  parameter int LVL_W  = $clog2(DEPTH + 1);
endpackage

// File: rtl/afifo_store.sv
module afifo_store #(
  parameter int DATA_W = afifo_pkg::DATA_W,
  parameter int DEPTH  = afifo_pkg::DEPTH,
  parameter int LVL_W  = afifo_pkg::LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              flush_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [LVL_W-1:0]  cnt_q;
  logic              ovf_q, unf_q;
  logic              full, empty, push_ok, pop_ok;

  assign full    = (cnt_q == FULL);
  assign empty   = (cnt_q == '0);
  assign push_ok = push_i && !full && !flush_i;
  assign pop_ok  = pop_i && !empty && !flush_i;

  // storage has no reset: a flush moves pointers only
  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (push_ok) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
      if (push_i && full) ovf_q <= 1'b1;
      if (pop_i && empty) unf_q <= 1'b1;
    end
  end

  assign rdata_o = mem_q[rd_q];
  assign level_o = cnt_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;
endmodule

// File: rtl/afifo_flags.sv
module afifo_flags #(
  parameter int DEPTH = afifo_pkg::DEPTH,
  parameter int TH_W  = afifo_pkg::TH_W,
  parameter int LVL_W = afifo_pkg::LVL_W,
  parameter bit IS_RX = 1'b0
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [TH_W-1:0]  thresh_i,
  input  logic             dma_en_i,
  output logic             thresh_o,
  output logic             dreq_o
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);
  logic [LVL_W-1:0] th_ext;
  assign th_ext = LVL_W'(thresh_i);

  generate
    if (IS_RX) begin : g_rx
      // field N means N+1 words
      assign thresh_o = (level_i >= th_ext + LVL_W'(1));
      assign dreq_o   = dma_en_i && (level_i != '0);
    end else begin : g_tx
      assign thresh_o = (level_i <= th_ext);
      assign dreq_o   = dma_en_i && (level_i != FULL);
    end
  endgenerate
endmodule

// File: rtl/audio_fifo_pair.sv
module audio_fifo_pair #(
  parameter int DATA_W = afifo_pkg::DATA_W,
  parameter int DEPTH  = afifo_pkg::DEPTH,
  parameter int TH_W   = afifo_pkg::TH_W,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_push_i,
  input  logic [DATA_W-1:0] tx_wdata_i,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_flush_i,
  input  logic [TH_W-1:0]   tx_thresh_i,
  input  logic              tx_dma_en_i,
  output logic [LVL_W-1:0]  tx_level_o,
  output logic              tx_thresh_o,
  output logic              tx_dreq_o,
  output logic              tx_ovf_o,
  output logic              tx_unf_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_wdata_i,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              rx_flush_i,
  input  logic [TH_W-1:0]   rx_thresh_i,
  input  logic              rx_dma_en_i,
  output logic [LVL_W-1:0]  rx_level_o,
  output logic              rx_thresh_o,
  output logic              rx_dreq_o,
  output logic              rx_ovf_o,
  output logic              rx_unf_o
);
  afifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_tx_store (
    .clk_i, .rst_ni,
    .push_i(tx_push_i), .pop_i(tx_pop_i), .flush_i(tx_flush_i),
    .wdata_i(tx_wdata_i), .rdata_o(tx_data_o), .level_o(tx_level_o),
    .ovf_o(tx_ovf_o), .unf_o(tx_unf_o)
  );

  afifo_flags #(.DEPTH(DEPTH), .TH_W(TH_W), .LVL_W(LVL_W), .IS_RX(1'b0)) u_tx_flags (
    .level_i(tx_level_o), .thresh_i(tx_thresh_i), .dma_en_i(tx_dma_en_i),
    .thresh_o(tx_thresh_o), .dreq_o(tx_dreq_o)
  );

  afifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_rx_store (
    .clk_i, .rst_ni,
    .push_i(rx_push_i), .pop_i(rx_pop_i), .flush_i(rx_flush_i),
    .wdata_i(rx_wdata_i), .rdata_o(rx_data_o), .level_o(rx_level_o),
    .ovf_o(rx_ovf_o), .unf_o(rx_unf_o)
  );

  afifo_flags #(.DEPTH(DEPTH), .TH_W(TH_W), .LVL_W(LVL_W), .IS_RX(1'b1)) u_rx_flags (
    .level_i(rx_level_o), .thresh_i(rx_thresh_i), .dma_en_i(rx_dma_en_i),
    .thresh_o(rx_thresh_o), .dreq_o(rx_dreq_o)
  );
endmodule

// File: rtl/afifo_pair_chk.sv
module afifo_pair_chk #(
  parameter int DEPTH = afifo_pkg::DEPTH,
  parameter int LVL_W = afifo_pkg::LVL_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_push_i,
  input logic             tx_pop_i,
  input logic             tx_flush_i,
  input logic [LVL_W-1:0] tx_level_o,
  input logic             tx_dreq_o,
  input logic             tx_ovf_o,
  input logic             tx_unf_o,
  input logic             rx_push_i,
  input logic             rx_pop_i,
  input logic             rx_flush_i,
  input logic [LVL_W-1:0] rx_level_o,
  input logic             rx_dreq_o,
  input logic             rx_ovf_o,
  input logic             rx_unf_o
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  assert_level_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_level_o <= FULL && rx_level_o <= FULL);

  assert_tx_flush_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush_i |=> (tx_level_o == '0) && !tx_ovf_o && !tx_unf_o);

  assert_rx_flush_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_i |=> (rx_level_o == '0) && !rx_ovf_o && !rx_unf_o);

  assert_tx_dreq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dreq_o |-> tx_level_o != FULL);

  assert_rx_dreq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dreq_o |-> rx_level_o != '0);

  assert_tx_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push_i && tx_level_o == FULL && !tx_flush_i) |=> tx_ovf_o);

  assert_tx_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ovf_o && !tx_flush_i) |=> tx_ovf_o);

  assert_rx_underflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop_i && rx_level_o == '0 && !rx_flush_i) |=> rx_unf_o && rx_level_o <= LVL_W'(1));

  assert_rx_unf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_unf_o && !rx_flush_i) |=> rx_unf_o);

  assert_tx_pushpop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push_i && tx_pop_i && !tx_flush_i && tx_level_o != '0 && tx_level_o != FULL)
      |=> $stable(tx_level_o));

  assert_rx_pushpop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_pop_i && !rx_flush_i && rx_level_o != '0 && rx_level_o != FULL)
      |=> $stable(rx_level_o));
endmodule

bind audio_fifo_pair afifo_pair_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .tx_push_i(tx_push_i), .tx_pop_i(tx_pop_i), .tx_flush_i(tx_flush_i),
  .tx_level_o(tx_level_o), .tx_dreq_o(tx_dreq_o), .tx_ovf_o(tx_ovf_o), .tx_unf_o(tx_unf_o),
  .rx_push_i(rx_push_i), .rx_pop_i(rx_pop_i), .rx_flush_i(rx_flush_i),
  .rx_level_o(rx_level_o), .rx_dreq_o(rx_dreq_o), .rx_ovf_o(rx_ovf_o), .rx_unf_o(rx_unf_o)
);

// File: tb/audio_fifo_pair_bench.sv
module audio_fifo_pair_bench;
  localparam int DW = 32;
  localparam int DP = 8;
  localparam int TW = 3;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          tx_push = 0, tx_pop = 0, tx_flush = 0, tx_en = 0;
  logic          rx_push = 0, rx_pop = 0, rx_flush = 0, rx_en = 0;
  logic [DW-1:0] tx_wd = '0, rx_wd = '0;
  logic [TW-1:0] tx_th = '0, rx_th = '0;
  logic [DW-1:0] tx_q, rx_q;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic          tx_thr, rx_thr, tx_dr, rx_dr, tx_ov, rx_ov, tx_un, rx_un;

  audio_fifo_pair u_audio_fifo_pair (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_push_i(tx_push), .tx_wdata_i(tx_wd), .tx_pop_i(tx_pop), .tx_data_o(tx_q),
    .tx_flush_i(tx_flush), .tx_thresh_i(tx_th), .tx_dma_en_i(tx_en),
    .tx_level_o(tx_lvl), .tx_thresh_o(tx_thr), .tx_dreq_o(tx_dr),
    .tx_ovf_o(tx_ov), .tx_unf_o(tx_un),
    .rx_push_i(rx_push), .rx_wdata_i(rx_wd), .rx_pop_i(rx_pop), .rx_data_o(rx_q),
    .rx_flush_i(rx_flush), .rx_thresh_i(rx_th), .rx_dma_en_i(rx_en),
    .rx_level_o(rx_lvl), .rx_thresh_o(rx_thr), .rx_dreq_o(rx_dr),
    .rx_ovf_o(rx_ov), .rx_unf_o(rx_un)
  );

  int n_vec = 0, n_bad = 0;

  // reference model, index 0 = tx, 1 = rx
  logic [DW-1:0] m_mem [2][DP];
  bit            m_val [2][DP];
  int            m_rp [2], m_wp [2], m_cnt [2];
  bit            m_ov [2], m_un [2];

  task automatic chk(string req, string what, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_step(int s, bit pu, bit po, bit fl, logic [DW-1:0] d);
    bit pa, pb;
    if (fl) begin
      m_rp[s] = 0; m_wp[s] = 0; m_cnt[s] = 0; m_ov[s] = 0; m_un[s] = 0;
    end else begin
      pa = pu && m_cnt[s] < DP;
      pb = po && m_cnt[s] > 0;
      if (pu && !pa) m_ov[s] = 1;
      if (po && !pb) m_un[s] = 1;
      if (pa) begin
        m_mem[s][m_wp[s]] = d; m_val[s][m_wp[s]] = 1; m_wp[s] = (m_wp[s] + 1) % DP;
      end
      if (pb) m_rp[s] = (m_rp[s] + 1) % DP;
      m_cnt[s] = m_cnt[s] + int'(pa) - int'(pb);
    end
  endtask

  task automatic check_all();
    chk("R2", "tx level", tx_lvl, m_cnt[0]);
    chk("R2", "rx level", rx_lvl, m_cnt[1]);
    if (m_val[0][m_rp[0]]) chk(m_cnt[0] > 0 ? "R2" : "R6", "tx data", tx_q, m_mem[0][m_rp[0]]);
    if (m_val[1][m_rp[1]]) chk(m_cnt[1] > 0 ? "R2" : "R6", "rx data", rx_q, m_mem[1][m_rp[1]]);
    chk("R3", "tx thresh", tx_thr, m_cnt[0] <= int'(tx_th));
    chk("R4", "rx thresh", rx_thr, m_cnt[1] >= int'(rx_th) + 1);
    chk("R7", "tx dreq", tx_dr, tx_en && m_cnt[0] < DP);
    chk("R8", "rx dreq", rx_dr, rx_en && m_cnt[1] > 0);
    chk("R9", "tx ovf", tx_ov, m_ov[0]);
    chk("R9", "rx ovf", rx_ov, m_ov[1]);
    chk("R10", "tx unf", tx_un, m_un[0]);
    chk("R10", "rx unf", rx_un, m_un[1]);
  endtask

  int seq = 0;
  // one clock with the given controls, model updated, outputs checked after the fall
  task automatic cyc(bit tpu, bit tpo, bit tfl, bit rpu, bit rpo, bit rfl);
    tx_push = tpu; tx_pop = tpo; tx_flush = tfl;
    rx_push = rpu; rx_pop = rpo; rx_flush = rfl;
    tx_wd = 32'hA500_0000 + seq; rx_wd = 32'h5A00_0000 + seq; seq++;
    @(posedge clk);
    model_step(0, tpu, tpo, tfl, tx_wd);
    model_step(1, rpu, rpo, rfl, rx_wd);
    @(negedge clk);
    tx_push = 0; tx_pop = 0; tx_flush = 0; rx_push = 0; rx_pop = 0; rx_flush = 0;
    check_all();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int s = 0; s < 2; s++) begin
      m_rp[s] = 0; m_wp[s] = 0; m_cnt[s] = 0; m_ov[s] = 0; m_un[s] = 0;
      for (int i = 0; i < DP; i++) m_val[s][i] = 0;
    end
    tx_en = 1; rx_en = 1; tx_th = 3'd5; rx_th = 3'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "tx level", tx_lvl, 0);
    chk("R1", "rx level", rx_lvl, 0);
    chk("R1", "tx thresh", tx_thr, 1);
    chk("R1", "rx thresh", rx_thr, 0);
    chk("R1", "tx dreq", tx_dr, 1);
    chk("R1", "rx dreq", rx_dr, 0);
    chk("R1", "flags", {tx_ov, tx_un, rx_ov, rx_un}, 0);

    // sweep every level 0..8 against every threshold field and both enables
    for (int lv = 0; lv <= DP; lv++) begin
      for (int th = 0; th < 8; th++) begin
        for (int en = 0; en < 2; en++) begin
          tx_th = TW'(th); rx_th = TW'(th); tx_en = en[0]; rx_en = en[0];
          #1;
          chk("R3", "tx thresh sweep", tx_thr, lv <= th);
          chk("R4", "rx thresh sweep", rx_thr, lv >= th + 1);
          chk("R7", "tx dreq sweep", tx_dr, en == 1 && lv < DP);
          chk("R8", "rx dreq sweep", rx_dr, en == 1 && lv > 0);
        end
      end
      tx_en = 1; rx_en = 1; tx_th = 3'd3; rx_th = 3'd4;
      if (lv < DP) cyc(1, 0, 0, 1, 0, 0);
    end

    // R9 push into full, then push+pop at full: push dropped, pop taken
    cyc(1, 0, 0, 1, 0, 0);
    chk("R9", "tx level held at full", tx_lvl, 8);
    cyc(1, 1, 0, 1, 1, 0);
    chk("R9", "tx level after push+pop at full", tx_lvl, 7);
    // R11 push+pop mid-level
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 1, 1, 0);
    chk("R11", "rx level steady", rx_lvl, 7);
    // R2 drain in order
    for (int i = 0; i < 7; i++) cyc(0, 1, 0, 0, 1, 0);
    chk("R2", "tx drained", tx_lvl, 0);
    // R10 pop when empty, then push+pop at empty
    cyc(0, 1, 0, 0, 1, 0);
    chk("R10", "rx unf set", rx_un, 1);
    cyc(1, 1, 0, 1, 1, 0);
    chk("R10", "rx level after push+pop at empty", rx_lvl, 1);

    // R5 flush wins over push and pop, clears sticky flags
    cyc(1, 0, 0, 1, 0, 0);
    cyc(1, 0, 0, 1, 0, 0);
    cyc(1, 1, 1, 1, 1, 1);
    chk("R5", "tx level after flush", tx_lvl, 0);
    chk("R5", "rx flags after flush", {rx_ov, rx_un}, 0);
    // R6 storage kept: empty output shows slot 0
    chk("R6", "tx slot0 kept", tx_q, m_mem[0][0]);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R5", "tx pointer restarted", tx_q, m_mem[0][0]);
    // R5 held flush keeps the buffer empty each cycle
    cyc(1, 0, 1, 1, 0, 1);
    cyc(1, 0, 1, 1, 0, 1);
    chk("R5", "rx held flush", rx_lvl, 0);

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_th = lfsr[2:0]; rx_th = lfsr[5:3]; tx_en = lfsr[6]; rx_en = lfsr[7];
      cyc(lfsr[8] | lfsr[9], lfsr[10], lfsr[15:11] == 5'd0,
          lfsr[11], lfsr[12] | lfsr[13], lfsr[15:11] == 5'd31);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule